// File: doc/BRIEF.md
# Saturating Half-Word Arithmetic Shifter

This block is one datapath lane beside a 32-bit register file. It takes a 16-bit operand from either half of a source word and shifts it arithmetically by a signed count. The count is held in the low bits of a second word. Positive counts shift left, negative counts shift right.

A left shift that cannot be represented in 16 signed bits is clamped to the nearest signed limit, and an overflow flag is raised. The 16-bit result replaces one chosen half of the prior destination word. The other half passes through untouched. The merged 32-bit word and the flag are registered on the clock edge that samples a valid strobe.

Instruction decode and the register file itself sit outside the block. The lane only computes and holds the write-back value.

Top module: `hsh_shift_unit`

## Requirements
- R1: A count of zero returns the operand unchanged, for positive and negative operands alike, with the overflow flag clear.
- R2: A left shift whose result still fits in 16 signed bits gives the plain shifted value, e.g. 0xD002 by 1 gives 0xA004, 0xC005 by 1 gives 0x800A, 0x0001 by 1 gives 0x0002.
- R3: A negative operand whose left shift loses significant bits gives 0x8000, e.g. 0xA001 by 1; every nonzero negative operand shifted left by 15 or 16 gives 0x8000.
- R4: A positive operand whose left shift overflows gives 0x7FFF, e.g. 0x0001 by 15 or 0x4000 by 1.
- R5: The count is bits [5:0] of the count word read as two's complement (range -32 to +31); bits [31:6] of the count word have no effect.
- R6: A negative count -m performs an arithmetic right shift by m filling with the sign bit; m of 16 or more gives 0x0000 or 0xFFFF by operand sign; right shifts never set the overflow flag.
- R7: src_hi_i = 1 takes the operand from source bits [31:16], src_hi_i = 0 from bits [15:0].
- R8: dst_hi_i = 1 writes the result to bits [31:16] of the output word, dst_hi_i = 0 to bits [15:0]; the other half equals the matching half of prev_word_i.
- R9: The overflow flag is 1 exactly when saturation replaced the shifted value, otherwise 0.
- R10: Output word and flag update only on a rising edge where valid_i is 1, hold otherwise, and a synchronous reset clears both to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| valid_i | input | 1 | Sample the inputs on this edge |
| src_word_i | input | 32 | Word holding the operand |
| cnt_word_i | input | 32 | Word whose low bits carry the signed count |
| src_hi_i | input | 1 | Operand half select (1 = upper) |
| dst_hi_i | input | 1 | Destination half select (1 = upper) |
| prev_word_i | input | 32 | Prior destination contents |
| result_o | output | 32 | Registered merged word |
| ovf_o | output | 1 | Registered saturation flag |

## Verification
The hardest case to reach is the edge between fitting and saturating. An operand whose top bits match for exactly as many positions as the count is on the fitting side. One more bit of shift must clamp, and the clamp direction depends on the sign. The bench sweeps every count from -32 to +31 against operands placed right at that boundary: 0x4000, 0xC000, 0x8000, 0x7FFF, 0x0001 and 0xFFFF. It also writes the upper bits of the count word with junk, so that a wider count decode would be exposed.

// File: rtl/hsh_pkg.sv
package hsh_pkg;

   localparam int HSH_HALF_W = 16;
   localparam int HSH_CNT_W  = 6;

   typedef enum logic {
      HALF_LO = 1'b0,
      HALF_HI = 1'b1
   } half_sel_e;

endpackage

// File: rtl/hsh_half_pick.sv
module hsh_half_pick #(
   parameter int HALF_W = 16
) (
   input  logic [2*HALF_W-1:0] word_i,
   input  logic                hi_i,
   output logic [HALF_W-1:0]   half_o
);
   import hsh_pkg::*;

   logic [HALF_W-1:0] halves [2];

   for (genvar h = 0; h < 2; h++) begin : g_split
      assign halves[h] = word_i[h*HALF_W +: HALF_W];
   end

   always_comb begin
      half_o = (half_sel_e'(hi_i) == HALF_HI) ? halves[1] : halves[0];
   end
endmodule

// File: rtl/hsh_sat_shift.sv
module hsh_sat_shift #(
   parameter int DATA_W = 16,
   parameter int CNT_W  = 6
) (
   input  logic [DATA_W-1:0] operand_i,
   input  logic [CNT_W-1:0]  count_i,
   output logic [DATA_W-1:0] value_o,
   output logic              sat_o
);
   // Widest left shift is 2**(CNT_W-1)-1, so this width never drops a bit.
   localparam int EXT_W  = DATA_W + (1 << (CNT_W - 1));
   localparam int TOP_W  = EXT_W - DATA_W + 1;

   localparam logic [DATA_W-1:0] POS_LIM = {1'b0, {(DATA_W-1){1'b1}}};
   localparam logic [DATA_W-1:0] NEG_LIM = {1'b1, {(DATA_W-1){1'b0}}};

   logic              go_left;
   logic [CNT_W-1:0]  mag;
   logic signed [EXT_W-1:0] stage_v [CNT_W+1];
   logic [TOP_W-1:0]  top_bits;
   logic              fits;

   assign go_left = ~count_i[CNT_W-1];
   assign mag     = go_left ? count_i : (~count_i + CNT_W'(1));

   assign stage_v[0] = {{(EXT_W-DATA_W){operand_i[DATA_W-1]}}, operand_i};

   // One stage per magnitude bit, each moving by a power of two.
   for (genvar g = 0; g < CNT_W; g++) begin : g_stage
      localparam int STEP = 1 << g;
      always_comb begin
         if (!mag[g])
            stage_v[g+1] = stage_v[g];
         else if (go_left)
            stage_v[g+1] = stage_v[g] <<< STEP;
         else
            stage_v[g+1] = stage_v[g] >>> STEP;
      end
   end

   // Result fits when every bit from the result sign upward agrees.
   assign top_bits = stage_v[CNT_W][EXT_W-1:DATA_W-1];
   assign fits     = (&top_bits) | ~(|top_bits);

   always_comb begin
      sat_o   = go_left & ~fits;
      value_o = stage_v[CNT_W][DATA_W-1:0];
      if (sat_o)
         value_o = operand_i[DATA_W-1] ? NEG_LIM : POS_LIM;
   end
endmodule

// File: rtl/hsh_half_merge.sv
module hsh_half_merge #(
   parameter int HALF_W = 16
) (
   input  logic [2*HALF_W-1:0] prev_i,
   input  logic [HALF_W-1:0]   new_i,
   input  logic                hi_i,
   output logic [2*HALF_W-1:0] word_o
);
   import hsh_pkg::*;

   for (genvar h = 0; h < 2; h++) begin : g_lane
      localparam half_sel_e MINE = (h == 1) ? HALF_HI : HALF_LO;
      assign word_o[h*HALF_W +: HALF_W] =
         (half_sel_e'(hi_i) == MINE) ? new_i : prev_i[h*HALF_W +: HALF_W];
   end
endmodule

// File: rtl/hsh_shift_unit.sv
module hsh_shift_unit #(
   parameter int DATA_W = hsh_pkg::HSH_HALF_W,
   parameter int CNT_W  = hsh_pkg::HSH_CNT_W
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  valid_i,
   input  logic [2*DATA_W-1:0]   src_word_i,
   input  logic [2*DATA_W-1:0]   cnt_word_i,
   input  logic                  src_hi_i,
   input  logic                  dst_hi_i,
   input  logic [2*DATA_W-1:0]   prev_word_i,
   output logic [2*DATA_W-1:0]   result_o,
   output logic                  ovf_o
);
   localparam int WORD_W = 2 * DATA_W;

   if (DATA_W < 2) begin : g_bad_data
      $error("hsh_shift_unit: DATA_W must be at least 2");
   end
   if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt
      $error("hsh_shift_unit: CNT_W must lie in 2..DATA_W");
   end

   logic [DATA_W-1:0] operand;
   logic [DATA_W-1:0] shifted;
   logic              sat;
   logic [WORD_W-1:0] merged;
   logic              cnt_unused;

   assign cnt_unused = ^cnt_word_i[WORD_W-1:CNT_W];

   hsh_half_pick #(.HALF_W(DATA_W)) u_pick (
      .word_i (src_word_i),
      .hi_i   (src_hi_i),
      .half_o (operand)
   );

   hsh_sat_shift #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_shift (
      .operand_i (operand),
      .count_i   (cnt_word_i[CNT_W-1:0]),
      .value_o   (shifted),
      .sat_o     (sat)
   );

   hsh_half_merge #(.HALF_W(DATA_W)) u_merge (
      .prev_i (prev_word_i),
      .new_i  (shifted),
      .hi_i   (dst_hi_i),
      .word_o (merged)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         result_o <= '0;
         ovf_o    <= 1'b0;
      end else if (valid_i) begin
         result_o <= merged;
         ovf_o    <= sat;
      end
   end
endmodule

// File: rtl/hsh_shift_unit_chk.sv
module hsh_shift_unit_chk #(
   parameter int DATA_W = 16,
   parameter int CNT_W  = 6
) (
   input logic                clk,
   input logic                rst,
   input logic                valid_i,
   input logic [2*DATA_W-1:0] src_word_i,
   input logic [2*DATA_W-1:0] cnt_word_i,
   input logic                src_hi_i,
   input logic                dst_hi_i,
   input logic [2*DATA_W-1:0] prev_word_i,
   input logic [2*DATA_W-1:0] result_o,
   input logic                ovf_o
);
   localparam logic [DATA_W-1:0] POS_LIM = {1'b0, {(DATA_W-1){1'b1}}};
   localparam logic [DATA_W-1:0] NEG_LIM = {1'b1, {(DATA_W-1){1'b0}}};

   logic cnt_unused;
   assign cnt_unused = ^cnt_word_i[2*DATA_W-1:CNT_W];

   // R10: reset clears the registered outputs
   p_reset_clear_r10: assert property (@(posedge clk)
      rst |=> (result_o == '0 && !ovf_o));

   // R10: no strobe, no change
   p_hold_idle_r10: assert property (@(posedge clk) disable iff (rst)
      !valid_i |=> ($stable(result_o) && $stable(ovf_o)));

   // R8: untouched half comes from the prior word
   p_keep_low_r8: assert property (@(posedge clk) disable iff (rst)
      (valid_i && dst_hi_i) |=> result_o[DATA_W-1:0] == $past(prev_word_i[DATA_W-1:0]));
   p_keep_high_r8: assert property (@(posedge clk) disable iff (rst)
      (valid_i && !dst_hi_i) |=> result_o[2*DATA_W-1:DATA_W] == $past(prev_word_i[2*DATA_W-1:DATA_W]));

   // R1, R7: zero count passes the selected half through
   p_zero_count_r1: assert property (@(posedge clk) disable iff (rst)
      (valid_i && !src_hi_i && !dst_hi_i && cnt_word_i[CNT_W-1:0] == '0)
      |=> (result_o[DATA_W-1:0] == $past(src_word_i[DATA_W-1:0]) && !ovf_o));
   p_src_high_r7: assert property (@(posedge clk) disable iff (rst)
      (valid_i && src_hi_i && !dst_hi_i && cnt_word_i[CNT_W-1:0] == '0)
      |=> result_o[DATA_W-1:0] == $past(src_word_i[2*DATA_W-1:DATA_W]));

   // R6: right shifts never flag
   p_right_no_flag_r6: assert property (@(posedge clk) disable iff (rst)
      (valid_i && cnt_word_i[CNT_W-1]) |=> !ovf_o);

   // R9: a raised flag always carries a signed limit
   p_flag_limit_r9: assert property (@(posedge clk) disable iff (rst)
      (valid_i && !dst_hi_i) |=> (!ovf_o || result_o[DATA_W-1:0] == POS_LIM
                                        || result_o[DATA_W-1:0] == NEG_LIM));
   p_flag_limit_hi_r9: assert property (@(posedge clk) disable iff (rst)
      (valid_i && dst_hi_i) |=> (!ovf_o || result_o[2*DATA_W-1:DATA_W] == POS_LIM
                                        || result_o[2*DATA_W-1:DATA_W] == NEG_LIM));
endmodule

bind hsh_shift_unit hsh_shift_unit_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
   .clk         (clk),
   .rst         (rst),
   .valid_i     (valid_i),
   .src_word_i  (src_word_i),
   .cnt_word_i  (cnt_word_i),
   .src_hi_i    (src_hi_i),
   .dst_hi_i    (dst_hi_i),
   .prev_word_i (prev_word_i),
   .result_o    (result_o),
   .ovf_o       (ovf_o)
);

// File: tb/hsh_shift_unit_tb.sv
`timescale 1ns/1ps
module hsh_shift_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        valid_i = 1'b0;
   logic [31:0] src_word_i = '0;
   logic [31:0] cnt_word_i = '0;
   logic        src_hi_i = 1'b0;
   logic        dst_hi_i = 1'b0;
   logic [31:0] prev_word_i = '0;
   logic [31:0] result_o;
   logic        ovf_o;

   int  n_vec  = 0;
   int  n_bad  = 0;
   bit  done   = 1'b0;

   always #2.5 clk = ~clk;

   hsh_shift_unit dut_i (
      .clk(clk), .rst(rst), .valid_i(valid_i),
      .src_word_i(src_word_i), .cnt_word_i(cnt_word_i),
      .src_hi_i(src_hi_i), .dst_hi_i(dst_hi_i),
      .prev_word_i(prev_word_i),
      .result_o(result_o), .ovf_o(ovf_o)
   );

   // Reference: {flag, 16-bit value}, from the requirement text.
   function automatic logic [16:0] ref_shift(logic [15:0] op, logic [5:0] c);
      longint v  = longint'(signed'(op));
      int     ci = int'(signed'(c));
      if (ci >= 0) begin
         v = v <<< ci;
         if (v > 32767)  return {1'b1, 16'h7FFF};
         if (v < -32768) return {1'b1, 16'h8000};
         return {1'b0, v[15:0]};
      end
      v = v >>> (-ci);
      return {1'b0, v[15:0]};
   endfunction

   task automatic compare(string tag, logic [32:0] act, logic [32:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got word=%h flag=%b, expected word=%h flag=%b",
                  tag, act[32:1], act[0], exp[32:1], exp[0]);
      end
   endtask

   task automatic apply(logic [31:0] s, logic [31:0] c, logic sh, logic dh, logic [31:0] p);
      @(negedge clk);
      src_word_i = s; cnt_word_i = c; src_hi_i = sh; dst_hi_i = dh; prev_word_i = p;
      valid_i = 1'b1;
      @(negedge clk);
      valid_i = 1'b0;
   endtask

   task automatic vec(string tag, logic [31:0] s, logic [31:0] c, logic sh, logic dh,
                      logic [31:0] p, logic [15:0] exp_half, logic exp_flag);
      logic [31:0] w;
      apply(s, c, sh, dh, p);
      w = dh ? {exp_half, p[15:0]} : {p[31:16], exp_half};
      compare(tag, {result_o, ovf_o}, {w, exp_flag});
   endtask

   task automatic t_reset();
      compare("R10 reset state", {result_o, ovf_o}, 33'd0);
   endtask

   task automatic t_zero_count();
      vec("R1 zero pos", 32'h0000_0007, 32'h0, 0, 0, 32'h0, 16'h0007, 0);
      vec("R1 zero neg", 32'h0000_C003, 32'h0, 0, 0, 32'h0, 16'hC003, 0);
      vec("R1 zero zero", 32'h0, 32'h0, 0, 0, 32'h0, 16'h0000, 0);
   endtask

   task automatic t_left_plain();
      vec("R2 D002<<1", 32'h0000_D002, 32'd1, 0, 0, 32'h0, 16'hA004, 0);
      vec("R2 C005<<1", 32'h0000_C005, 32'd1, 0, 0, 32'h0, 16'h800A, 0);
      vec("R2 0001<<1", 32'h0000_0001, 32'd1, 0, 0, 32'h0, 16'h0002, 0);
      vec("R2 0001<<14", 32'h0000_0001, 32'd14, 0, 0, 32'h0, 16'h4000, 0);
   endtask

   task automatic t_neg_sat();
      vec("R3 A001<<1", 32'h0000_A001, 32'd1, 0, 0, 32'h0, 16'h8000, 1);
      vec("R3 F004<<15", 32'h0000_F004, 32'd15, 0, 0, 32'h0, 16'h8000, 1);
      vec("R3 C001<<16", 32'h0000_C001, 32'd16, 0, 0, 32'h0, 16'h8000, 1);
      vec("R3 FFFF<<15", 32'h0000_FFFF, 32'd15, 0, 0, 32'h0, 16'h8000, 0);
   endtask

   task automatic t_pos_sat();
      vec("R4 4000<<1", 32'h0000_4000, 32'd1, 0, 0, 32'h0, 16'h7FFF, 1);
      vec("R4 0001<<15", 32'h0000_0001, 32'd15, 0, 0, 32'h0, 16'h7FFF, 1);
      vec("R9 0000<<31 no flag", 32'h0, 32'd31, 0, 0, 32'h0, 16'h0000, 0);
   endtask

   task automatic t_count_field();
      vec("R5 junk upper bits", 32'h0000_0003, 32'hABCD_FFC1, 0, 0, 32'h0, 16'h0006, 0);
      vec("R5 bit6 ignored", 32'h0000_0005, 32'h0000_0040, 0, 0, 32'h0, 16'h0005, 0);
      vec("R5 -32 count", 32'h0000_8000, 32'h0000_0020, 0, 0, 32'h0, 16'hFFFF, 0);
   endtask

   task automatic t_right();
      vec("R6 8000>>1", 32'h0000_8000, 32'h3F, 0, 0, 32'h0, 16'hC000, 0);
      vec("R6 7FFF>>4", 32'h0000_7FFF, 32'h3C, 0, 0, 32'h0, 16'h07FF, 0);
      vec("R6 A000>>16", 32'h0000_A000, 32'h30, 0, 0, 32'h0, 16'hFFFF, 0);
      vec("R6 7000>>20", 32'h0000_7000, 32'h2C, 0, 0, 32'h0, 16'h0000, 0);
   endtask

   task automatic t_halves();
      vec("R7 src high", 32'h0003_1111, 32'd2, 1, 0, 32'h5555_AAAA, 16'h000C, 0);
      vec("R8 dst high", 32'h2222_D003, 32'd1, 0, 1, 32'h5555_AAAA, 16'hA006, 0);
      vec("R8 hi to hi sat", 32'hA001_0000, 32'd1, 1, 1, 32'h1234_5678, 16'h8000, 1);
   endtask

   task automatic t_hold_and_reset();
      apply(32'h0000_0011, 32'd1, 0, 0, 32'hFFFF_0000);
      @(negedge clk);
      src_word_i = 32'hFFFF_FFFF; cnt_word_i = 32'd9; prev_word_i = 32'h0;
      dst_hi_i = 1'b1;
      @(negedge clk); @(negedge clk);
      compare("R10 hold without valid", {result_o, ovf_o}, {32'hFFFF_0022, 1'b0});
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      compare("R10 sync reset", {result_o, ovf_o}, 33'd0);
   endtask

   task automatic t_sweep();
      logic [15:0] ops [6] = '{16'h4000, 16'hC000, 16'h8000, 16'h7FFF, 16'h0001, 16'hFFFF};
      for (int i = 0; i < 6; i++) begin
         for (int c = 0; c < 64; c++) begin
            logic [16:0] r = ref_shift(ops[i], 6'(c));
            vec("R9 sweep", {16'h0, ops[i]}, {26'h2AAAAAA, 6'(c)}, 0, 0,
                32'h9876_0000, r[15:0], r[16]);
         end
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst = 1'b0;
      t_zero_count();
      t_left_plain();
      t_neg_sat();
      t_pos_sat();
      t_count_field();
      t_right();
      t_halves();
      t_hold_and_reset();
      t_sweep();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_bad++;
         $display("FAIL watchdog: got no completion, expected finish before timeout");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule